// File: doc/BRIEF.md
# UART Receive Break Detector

This block sits next to a UART receiver and tells a genuine line break apart from an ordinary framing error. The receiver's framing logic gives it a strobe for every sampled bit of a character frame, marks the stop-bit strobe, and supplies the sampled value. If the frame's data bits, its parity bit when present, and its stop bit were all sampled low, the block treats the frame as a break instead of a framing error. It then raises a sticky break status flag and enters a break-in-progress state.

While a break is in progress the block ignores all bit strobes. Its `brk_active` output tells the receiver to hold off its start-bit search. The block then watches the line on each sample tick. The receiver provides sixteen ticks per bit in asynchronous mode, or one tick per bit in synchronous mode. The break ends when the line has been high for two consecutive ticks in asynchronous mode, or on the first high tick in synchronous mode. The end of the break sets the status flag again. Software clears the flag with a one-cycle status-reset pulse.

Top module: `rx_break_detect`

## Requirements
- R1: A stop-bit strobe with `bit_val`=0 raises `brk_active` and `brk_flag` one cycle later, provided that no non-stop strobe since the previous stop strobe (or reset) carried `bit_val`=1.
- R2: A stop strobe with `bit_val`=0 that follows at least one high non-stop bit in the same frame gives a one-cycle `ferr_pulse` one cycle later and does not touch `brk_flag`. A break frame never produces `ferr_pulse`.
- R3: After reset `brk_flag`, `brk_active` and `ferr_pulse` are 0. `brk_flag` stays set until `sts_clr` is pulsed, and it reads 0 the cycle after a pulse when no set event coincides.
- R4: In asynchronous mode (`sync_mode`=0), a break ends when `rxd` is 1 on two consecutive `os_tick` samples. `brk_active` falls one cycle after the second of those ticks.
- R5: In asynchronous mode, an `os_tick` sample with `rxd`=0 during a break restarts the high-time count, so an isolated high tick never ends the break.
- R6: In synchronous mode (`sync_mode`=1), a break ends on the first `os_tick` sample with `rxd`=1.
- R7: The end of a break sets `brk_flag` one cycle after the ending tick, even if the flag was cleared during the break.
- R8: While `brk_active` is 1, bit strobes have no effect. They produce no `ferr_pulse`, start no new break and set no flag.
- R9: When a set event (break start or break end) and `sts_clr` occur in the same cycle, `brk_flag` is 1 afterwards.
- R10: A frame whose stop strobe carries `bit_val`=1 sets neither `brk_flag` nor `ferr_pulse`, and it resets the all-low tracking for the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_mode | input | 1 | 0 = 16x oversampled asynchronous, 1 = synchronous one sample per bit |
| os_tick | input | 1 | Line sample tick (oversampling tick or per-bit sample) |
| rxd | input | 1 | Sampled receive line |
| bit_stb | input | 1 | Receiver has sampled one frame bit |
| bit_is_stop | input | 1 | Qualifies `bit_stb` as the stop bit |
| bit_val | input | 1 | Value of the bit sampled at `bit_stb` |
| sts_clr | input | 1 | Status-reset pulse for the break flag |
| brk_flag | output | 1 | Sticky break status |
| brk_active | output | 1 | Break in progress; receiver holds off start-bit search |
| ferr_pulse | output | 1 | One-cycle framing error that is not a break |

## Verification
If the all-low tracking were wrong, the first stop strobe after the fault would show it within one cycle. A break would come out as `ferr_pulse` instead of `brk_flag`, or the other way round. A wrong high-time count would make `brk_active` fall one tick early or late, or never fall at all, visible the cycle after the relevant tick. A flag that lost a set against a clear would read 0 on the very next cycle. Because a behavioural model is compared against every output on every clock, each of these faults is caught in the cycle where it first appears.

// File: rtl/brk_pkg.sv
package brk_pkg;

    typedef enum logic {
        MODE_ASYNC = 1'b0,
        MODE_SYNC  = 1'b1
    } rx_mode_e;

endpackage

// File: rtl/brk_frame_qual.sv
module brk_frame_qual (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_stb,
    input  logic bit_is_stop,
    input  logic bit_val,
    input  logic brk_active,
    output logic brk_start,
    output logic ferr_pulse
);

    typedef struct packed {
        logic seen_high;
        logic ferr;
    } qual_t;

    qual_t s_d, s_q;
    logic  start_d;

    always_comb begin
        s_d      = s_q;
        s_d.ferr = 1'b0;
        start_d  = 1'b0;
        if (bit_stb && !brk_active) begin
            if (bit_is_stop) begin
                s_d.seen_high = 1'b0;
                if (!bit_val) begin
                    if (!s_q.seen_high) begin
                        start_d = 1'b1;
                    end else begin
                        s_d.ferr = 1'b1;
                    end
                end
            end else if (bit_val) begin
                s_d.seen_high = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign brk_start  = start_d;
    assign ferr_pulse = s_q.ferr;

    // R2: a break frame never yields a framing error
    assert_no_ferr_on_break_R2: assert property (@(posedge clk) disable iff (!rst_n)
        brk_start |=> !ferr_pulse);

    // R8: no new break while one is in progress
    assert_no_start_in_break_R8: assert property (@(posedge clk) disable iff (!rst_n)
        brk_active |-> !brk_start);

    // R8: strobes during a break produce no framing error
    assert_no_ferr_in_break_R8: assert property (@(posedge clk) disable iff (!rst_n)
        brk_active |=> !ferr_pulse);

endmodule

// File: rtl/brk_end_detect.sv
module brk_end_detect #(
    parameter int ASYNC_HI_TICKS = 2,
    parameter int SYNC_HI_TICKS  = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_mode,
    input  logic os_tick,
    input  logic rxd,
    input  logic brk_start,
    output logic brk_active,
    output logic brk_end
);

    import brk_pkg::*;

    localparam int MAX_TICKS = (ASYNC_HI_TICKS > SYNC_HI_TICKS) ? ASYNC_HI_TICKS : SYNC_HI_TICKS;
    localparam int CNT_W     = $clog2(MAX_TICKS + 1);

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
    } end_t;

    end_t             s_d, s_q;
    logic [CNT_W-1:0] thr;
    logic [CNT_W-1:0] cnt_inc;
    logic             end_d;
    rx_mode_e         mode;

    assign mode    = rx_mode_e'(sync_mode);
    assign thr     = (mode == MODE_SYNC) ? CNT_W'(SYNC_HI_TICKS) : CNT_W'(ASYNC_HI_TICKS);
    assign cnt_inc = s_q.cnt + CNT_W'(1);

    always_comb begin
        s_d   = s_q;
        end_d = 1'b0;
        if (!s_q.active) begin
            if (brk_start) begin
                s_d.active = 1'b1;
                s_d.cnt    = '0;
            end
        end else if (os_tick) begin
            if (rxd) begin
                if (cnt_inc >= thr) begin
                    end_d      = 1'b1;
                    s_d.active = 1'b0;
                    s_d.cnt    = '0;
                end else begin
                    s_d.cnt = cnt_inc;
                end
            end else begin
                s_d.cnt = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign brk_active = s_q.active;
    assign brk_end    = end_d;

    // R5: a low sample never ends a break
    assert_low_keeps_break_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_active && os_tick && !rxd) |=> brk_active);

    // R6: in synchronous mode the first high sample ends the break
    assert_sync_first_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_active && os_tick && rxd && sync_mode) |=> !brk_active);

    // R4: without a tick the break state holds
    assert_hold_without_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_active && !os_tick) |=> brk_active);

endmodule

// File: rtl/brk_status.sv
module brk_status (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic sts_clr,
    output logic brk_flag
);

    typedef struct packed {
        logic flag;
    } sts_t;

    sts_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (set_evt) begin
            s_d.flag = 1'b1;
        end else if (sts_clr) begin
            s_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign brk_flag = s_q.flag;

    // R9: a set event wins over a simultaneous clear
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> brk_flag);

    // R3: the flag is sticky without a clear
    assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_flag && !sts_clr) |=> brk_flag);

    // R3: a lone clear empties the flag
    assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_clr && !set_evt) |=> !brk_flag);

endmodule

// File: rtl/rx_break_detect.sv
module rx_break_detect #(
    parameter int ASYNC_HI_TICKS = 2,
    parameter int SYNC_HI_TICKS  = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_mode,
    input  logic os_tick,
    input  logic rxd,
    input  logic bit_stb,
    input  logic bit_is_stop,
    input  logic bit_val,
    input  logic sts_clr,
    output logic brk_flag,
    output logic brk_active,
    output logic ferr_pulse
);

    logic brk_start;
    logic brk_end;
    logic active_w;

    brk_frame_qual u_qual (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_stb    (bit_stb),
        .bit_is_stop(bit_is_stop),
        .bit_val    (bit_val),
        .brk_active (active_w),
        .brk_start  (brk_start),
        .ferr_pulse (ferr_pulse)
    );

    brk_end_detect #(
        .ASYNC_HI_TICKS(ASYNC_HI_TICKS),
        .SYNC_HI_TICKS (SYNC_HI_TICKS)
    ) u_end (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_mode (sync_mode),
        .os_tick   (os_tick),
        .rxd       (rxd),
        .brk_start (brk_start),
        .brk_active(active_w),
        .brk_end   (brk_end)
    );

    brk_status u_sts (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (brk_start | brk_end),
        .sts_clr (sts_clr),
        .brk_flag(brk_flag)
    );

    assign brk_active = active_w;

    // R1: a qualified all-low stop bit enters the break state
    assert_break_enters_R1: assert property (@(posedge clk) disable iff (!rst_n)
        brk_start |=> (brk_active && brk_flag));

    // R7: the end of a break raises the flag
    assert_end_sets_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        brk_end |=> (brk_flag && !brk_active));

endmodule

// File: tb/tb_rx_break_detect.sv
module tb_rx_break_detect;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sync_mode = 1'b0;
    logic os_tick = 1'b0;
    logic rxd = 1'b1;
    logic bit_stb = 1'b0;
    logic bit_is_stop = 1'b0;
    logic bit_val = 1'b0;
    logic sts_clr = 1'b0;
    logic brk_flag, brk_active, ferr_pulse;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    // behavioural reference state
    int m_seen = 0, m_active = 0, m_run = 0, m_flag = 0, m_ferr = 0;

    always #10 clk = ~clk;

    rx_break_detect dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_mode  (sync_mode),
        .os_tick    (os_tick),
        .rxd        (rxd),
        .bit_stb    (bit_stb),
        .bit_is_stop(bit_is_stop),
        .bit_val    (bit_val),
        .sts_clr    (sts_clr),
        .brk_flag   (brk_flag),
        .brk_active (brk_active),
        .ferr_pulse (ferr_pulse)
    );

    task automatic check(input string req, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // reference model, written from the requirements
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_seen = 0; m_active = 0; m_run = 0; m_flag = 0; m_ferr = 0;
        end else begin
            int began;
            int ended;
            int need;
            began = 0;
            ended = 0;
            need  = sync_mode ? 1 : 2;
            m_ferr = 0;
            if (m_active == 0) begin
                if (bit_stb) begin
                    if (bit_is_stop) begin
                        if (!bit_val) begin
                            if (m_seen == 0) began = 1;
                            else m_ferr = 1;
                        end
                        m_seen = 0;
                    end else if (bit_val) begin
                        m_seen = 1;
                    end
                end
                if (began != 0) begin
                    m_active = 1;
                    m_run = 0;
                end
            end else if (os_tick) begin
                if (rxd) begin
                    m_run++;
                    if (m_run >= need) begin
                        ended = 1;
                        m_active = 0;
                        m_run = 0;
                    end
                end else begin
                    m_run = 0;
                end
            end
            if (began != 0 || ended != 0) m_flag = 1;
            else if (sts_clr) m_flag = 0;
        end
    end

    // compare against the model every cycle
    always @(negedge clk) begin
        if (rst_n) begin
            check("R1 model brk_active", brk_active, m_active[0]);
            check("R3 model brk_flag", brk_flag, m_flag[0]);
            check("R2 model ferr_pulse", ferr_pulse, m_ferr[0]);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic strobe(input logic stop, input logic v, input logic clr);
        @(negedge clk);
        bit_stb = 1'b1; bit_is_stop = stop; bit_val = v; rxd = v; sts_clr = clr;
        @(negedge clk);
        bit_stb = 1'b0; bit_is_stop = 1'b0; sts_clr = 1'b0;
    endtask

    task automatic send_frame(input logic [8:0] bits, input int n, input logic stop, input logic clr);
        for (int i = 0; i < n; i++) strobe(1'b0, bits[i], 1'b0);
        strobe(1'b1, stop, clr);
    endtask

    task automatic tick(input logic v);
        @(negedge clk);
        os_tick = 1'b1; rxd = v;
        @(negedge clk);
        os_tick = 1'b0;
    endtask

    task automatic clr_pulse;
        @(negedge clk);
        sts_clr = 1'b1;
        @(negedge clk);
        sts_clr = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R3 reset flag", brk_flag, 1'b0);
        check("R3 reset active", brk_active, 1'b0);
        check("R3 reset ferr", ferr_pulse, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: good frame
        send_frame(9'h055, 8, 1'b1, 1'b0);
        check("R10 good frame flag", brk_flag, 1'b0);
        check("R10 good frame ferr", ferr_pulse, 1'b0);

        // R2: low stop with a high data bit
        send_frame(9'h010, 8, 1'b0, 1'b0);
        check("R2 framing error pulse", ferr_pulse, 1'b1);
        check("R2 framing error no flag", brk_flag, 1'b0);

        // R1: all low with parity
        send_frame(9'h000, 9, 1'b0, 1'b0);
        check("R1 break active", brk_active, 1'b1);
        check("R1 break flag", brk_flag, 1'b1);
        check("R2 break no ferr", ferr_pulse, 1'b0);

        clr_pulse();
        check("R3 clear during break", brk_flag, 1'b0);

        // R8: strobes ignored in break
        send_frame(9'h0F0, 8, 1'b0, 1'b0);
        check("R8 no ferr in break", ferr_pulse, 1'b0);
        send_frame(9'h000, 8, 1'b0, 1'b0);
        check("R8 no flag in break", brk_flag, 1'b0);
        check("R8 still active", brk_active, 1'b1);

        // R5 / R4 / R7: async end of break
        tick(1'b1);
        check("R4 one high tick", brk_active, 1'b1);
        tick(1'b0);
        check("R5 low restarts", brk_active, 1'b1);
        tick(1'b1);
        check("R5 isolated high", brk_active, 1'b1);
        tick(1'b1);
        check("R4 two high ticks end", brk_active, 1'b0);
        check("R7 end sets flag", brk_flag, 1'b1);

        // R9: set and clear together
        clr_pulse();
        send_frame(9'h000, 8, 1'b0, 1'b1);
        check("R9 set wins flag", brk_flag, 1'b1);
        check("R9 set wins active", brk_active, 1'b1);

        // R6: synchronous end
        sync_mode = 1'b1;
        clr_pulse();
        tick(1'b0);
        check("R6 low sample", brk_active, 1'b1);
        tick(1'b1);
        check("R6 first high ends", brk_active, 1'b0);
        check("R7 sync end flag", brk_flag, 1'b1);

        clr_pulse();
        check("R3 final clear", brk_flag, 1'b0);

        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule